// File: doc/BRIEF.md
# OTG One-Shot Countdown Timer

This block is a software-programmed single-shot timer. A 32-bit control word sets an arm flag and a tick count. The block counts device-clock ticks and emits a one-cycle timeout pulse when the count runs out. The pulse feeds an interrupt aggregator.

Ticks arrive on a clock-enable input. The device clock is nominally 60 MHz, and the enable marks one device-clock period in the fabric clock domain. A write with the arm flag set starts a countdown. A write with the flag clear discards any countdown in progress. Reading the port gives back the word last written, not the live count. The whole word reads as zero once the timer has fired.

Top module: `otg_oneshot_timer`

## Requirements
- R1: After reset, `rd_data` is zero, `timeout` is low and no countdown is pending.
- R2: After a write, `rd_data` shows all 32 written bits, including the unused bits 30:27, from the next cycle on. It keeps that value until the next write or an expiry.
- R3: A write with bit 31 set arms a countdown of N = bits 26:0. `timeout` pulses after exactly N+1 ticks have been counted.
- R4: The countdown advances only on cycles where `tick_en` is high. With `tick_en` low, the pending count is held.
- R5: A write with bit 31 set while a countdown is pending discards the old countdown and starts the new length from the beginning.
- R6: A write with bit 31 clear cancels a pending countdown, and no timeout follows it.
- R7: At expiry, `rd_data` becomes zero in the same cycle in which `timeout` goes high.
- R8: `timeout` is high for exactly one cycle per expiry.
- R9: A tick that coincides with a write is not counted. The write takes effect and the new countdown begins with the next tick.
- R10: A write of count zero with bit 31 set expires on the first tick after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Write strobe for the timer word |
| wr_data | input | 32 | Write data: bit 31 arm flag, bits 26:0 tick count |
| tick_en | input | 1 | Device-clock tick enable, one cycle per tick |
| rd_data | output | 32 | Readback of the timer word |
| timeout | output | 1 | One-cycle expiry pulse |

## Verification
The properties assume that a write and a tick in the same cycle resolve in favour of the write. They also assume that a pulse can only follow a cycle in which `tick_en` was sampled high. The properties do not assume that writes are spaced apart. The stimulus therefore drives `wr_en` together with `tick_en` on purpose, and it also issues back-to-back rewrites and cancels while a countdown is pending. Tick spacing is varied between every cycle and every third cycle, so that held-count behaviour is exercised. All counts are kept small so that each expiry falls inside the run.

// File: rtl/otg_tmr_pkg.sv
package otg_tmr_pkg;
  localparam int TMR_DATA_W  = 32;
  localparam int TMR_CNT_W   = 27;
  localparam int TMR_ARM_BIT = 31;
endpackage

// File: rtl/otg_tmr_reg.sv
module otg_tmr_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_d;
  logic              word_ce;

  always_comb begin
    word_ce = wr_en | clr;
    word_d  = word_q;
    if (wr_en)      word_d = wr_data;
    else if (clr)   word_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_ce) word_q <= word_d;
  end

  assign rd_data = word_q;
endmodule

// File: rtl/otg_tmr_cnt.sv
module otg_tmr_cnt #(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             cancel,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick_en,
  output logic             expire,
  output logic             pulse_o
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             step;
  logic             cnt_ce;

  always_comb begin
    step    = armed_q & tick_en & ~load & ~cancel;
    expire  = step & (cnt_q == CNT_ZERO);
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (load) begin
      armed_d = 1'b1;
      cnt_d   = load_val;
    end else if (cancel) begin
      armed_d = 1'b0;
    end else if (expire) begin
      armed_d = 1'b0;
    end else if (step) begin
      cnt_d   = cnt_q - CNT_ONE;
    end
    cnt_ce  = load | step;
    pulse_d = expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pulse_q <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/otg_oneshot_timer.sv
module otg_oneshot_timer
  import otg_tmr_pkg::*;
#(
  parameter int DATA_W  = TMR_DATA_W,
  parameter int CNT_W   = TMR_CNT_W,
  parameter int ARM_BIT = TMR_ARM_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              timeout
);
  logic             arm_wr;
  logic             cancel_wr;
  logic             expire;
  logic [CNT_W-1:0] cnt_field;

  assign arm_wr    = wr_en &  wr_data[ARM_BIT];
  assign cancel_wr = wr_en & ~wr_data[ARM_BIT];
  assign cnt_field = wr_data[CNT_W-1:0];

  otg_tmr_reg #(.DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .clr     (expire),
    .rd_data (rd_data)
  );

  otg_tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (arm_wr),
    .cancel   (cancel_wr),
    .load_val (cnt_field),
    .tick_en  (tick_en),
    .expire   (expire),
    .pulse_o  (timeout)
  );
endmodule

// File: rtl/otg_tmr_chk.sv
module otg_tmr_chk #(
  parameter int DATA_W  = 32,
  parameter int ARM_BIT = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              tick_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              timeout
);
  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data)); // R2
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (timeout || $stable(rd_data))); // R2
  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $past(tick_en)); // R4
  AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[ARM_BIT]) |=> !timeout); // R6
  AST_EXPIRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> rd_data == '0); // R7
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !timeout); // R9
endmodule

bind otg_oneshot_timer otg_tmr_chk #(.DATA_W(DATA_W), .ARM_BIT(ARM_BIT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .tick_en (tick_en),
  .rd_data (rd_data),
  .timeout (timeout)
);

// File: tb/otg_oneshot_timer_tb.sv
module otg_oneshot_timer_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        tick_en;
  logic [31:0] rd_data;
  logic        timeout;

  int    n_checks;
  int    n_fails;
  int    n_pulses;
  int    cycles;
  string cur_req;

  // behavioural reference state
  logic [31:0] m_word;
  bit          m_armed;
  longint      m_left;
  bit          m_pulse;

  otg_oneshot_timer dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .tick_en (tick_en),
    .rd_data (rd_data),
    .timeout (timeout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_word = 32'h0; m_armed = 0; m_left = 0; m_pulse = 0;
    end else begin
      m_pulse = 0;
      if (wr_en) begin
        m_word  = wr_data;
        m_armed = wr_data[31];
        m_left  = longint'(wr_data[26:0]);
      end else if (tick_en && m_armed) begin
        if (m_left == 0) begin
          m_armed = 0; m_word = 32'h0; m_pulse = 1;
        end else begin
          m_left = m_left - 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (timeout) n_pulses++;
    n_checks++;
    if (rd_data !== m_word || timeout !== m_pulse) begin
      n_fails++;
      $display("FAIL %s: rd_data=%h timeout=%b expected rd_data=%h timeout=%b",
               cur_req, rd_data, timeout, m_word, m_pulse);
    end
    if (cycles > 100000) begin
      n_fails++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  task automatic check_pulses(input string req, input int exp);
    n_checks++;
    if (n_pulses != exp) begin
      n_fails++;
      $display("FAIL %s: pulses=%0d expected=%0d", req, n_pulses, exp);
    end
  endtask

  task automatic run(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      tick_en = ((i % period) == period - 1);
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  task automatic wr(input logic [31:0] v, input logic tk);
    wr_en = 1'b1; wr_data = v; tick_en = tk;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  initial begin
    n_checks = 0; n_fails = 0; n_pulses = 0; cycles = 0;
    cur_req = "R1";
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tick_en = 1'b0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (rd_data !== 32'h0 || timeout !== 1'b0) begin
      n_fails++;
      $display("FAIL R1: rd_data=%h timeout=%b expected 0/0", rd_data, timeout);
    end
    rst_n = 1'b1;
    run(5, 1);
    check_pulses("R1", 0);

    cur_req = "R2"; n_pulses = 0;
    wr(32'h7A5A_5A5A, 1'b0);
    run(6, 1);
    wr(32'h0000_1234, 1'b1);
    run(4, 2);
    check_pulses("R2", 0);

    cur_req = "R3"; n_pulses = 0;
    wr(32'h8000_0005, 1'b0);
    run(12, 1);
    check_pulses("R3", 1);

    cur_req = "R4"; n_pulses = 0;
    wr(32'h8000_0003, 1'b0);
    run(20, 3);
    check_pulses("R4", 1);

    cur_req = "R5"; n_pulses = 0;
    wr(32'h8000_0004, 1'b0);
    run(2, 1);
    wr(32'h8000_0006, 1'b0);
    run(12, 1);
    check_pulses("R5", 1);

    cur_req = "R6"; n_pulses = 0;
    wr(32'h8000_0008, 1'b0);
    run(3, 1);
    wr(32'h0000_0008, 1'b1);
    run(20, 1);
    check_pulses("R6", 0);

    cur_req = "R7 R8"; n_pulses = 0;
    wr(32'hF800_0002, 1'b0);
    run(8, 2);
    check_pulses("R8", 1);

    cur_req = "R9"; n_pulses = 0;
    wr(32'h8000_0001, 1'b1);
    run(1, 1);
    wr(32'h8000_0001, 1'b1);
    run(6, 1);
    check_pulses("R9", 1);

    cur_req = "R10"; n_pulses = 0;
    wr(32'h8000_0000, 1'b0);
    run(3, 1);
    check_pulses("R10", 1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule